// File: doc/BRIEF.md
# Bit-Serial Overlapped-Step ALU Sequencer

This block evaluates one of eight two-operand functions over a WIDTH-bit word by walking a single 1-bit slice across the operand bits, least significant first. Every bit moves through three phases: it is evaluated, its state is moved into a holding stage, and the result bit is produced. The produce phase of bit i shares a step with the evaluate phase of bit i+1. The carry or borrow of each bit goes straight into the next bit. A complete operation therefore takes 2·WIDTH+1 steps, one clock cycle per step.

The result bit is formed by an equality decision between two small sums that the evaluate phase builds. Equal sums give 0 and unequal sums give 1, and an optional inversion follows the decision. The caller presents the operands and a function code with a one-cycle start, then waits for the done pulse. The caller can reuse the block once done has pulsed.

Top module: `alu_seq_top`

## Requirements
- R1: Function codes are AND=0, OR=1, NAND=2, NOR=3, XOR=4, XNOR=5. For each of these, result_o at done is the bitwise function of the operands captured at start.
- R2: Code 6 (ADD) gives result_o = (A+B) mod 2^WIDTH and carry_o = the carry out of the top bit. Bit 0 takes a carry-in of 0.
- R3: Code 7 (SUB) gives result_o = (A−B) mod 2^WIDTH, with bit 0 taking a borrow-in of 0. Each bit produces a borrow for (a,b,bin) in {001, 010, 011, 111}, so carry_o = 1 exactly when A < B unsigned.
- R4: For codes 0 to 5, carry_o is 0 at done.
- R5: done_o is high for exactly one cycle. It rises 2·WIDTH+1 clock edges after the edge that accepted start. result_o and carry_o are final at that time and hold until the next accepted start.
- R6: A start asserted while an operation is running is ignored. Its operands and code do not affect the result, and it produces no extra done pulse.
- R7: An accepted start clears result_o and carry_o. Bit i of result_o takes its final value at the (2i+3)-th edge after the start edge, and higher bits stay 0 until their own edge.
- R8: After reset, result_o, carry_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_a_i | input | WIDTH | Operand A |
| op_b_i | input | WIDTH | Operand B |
| func_i | input | 3 | Function code |
| result_o | output | WIDTH | Result word, filled bit by bit |
| carry_o | output | 1 | Carry (ADD) or borrow (SUB) out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hardest to reach from the ports. The first is a start that arrives in the middle of a run. The bench brings it about by asserting start with different operands and a different code a few cycles after a real start, then confirms that the result matches the first request. It also confirms that no second done pulse follows in a window longer than a full run. The second is the overlap of produce and evaluate phases, which can only be seen from the ports as the order in which result bits fill in. One run with all-ones operands is sampled at every cycle, and the partial word is compared against the bit-per-two-cycle schedule. Random operands and codes, together with the carry and borrow extremes, cover the chaining of carry and borrow between bits.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;
  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_NAND = 3'd2,
    FN_NOR  = 3'd3,
    FN_XOR  = 3'd4,
    FN_XNOR = 3'd5,
    FN_ADD  = 3'd6,
    FN_SUB  = 3'd7
  } alu_fn_e;

  // evaluate-phase state of one bit: two sums to compare, output inversion, carry
  typedef struct packed {
    logic [1:0] sum_p;
    logic [1:0] sum_n;
    logic       inv;
    logic       cout;
  } slice_st_t;
endpackage

// File: rtl/alu_seq_slice.sv
module alu_seq_slice
  import alu_seq_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      cin_i,
  input  alu_fn_e   fn_i,
  output slice_st_t st_o
);
  logic arith, c, maj, borrow;

  assign arith  = (fn_i == FN_ADD) || (fn_i == FN_SUB);
  assign c      = arith & cin_i;
  assign maj    = (a_i & b_i) | (a_i & c) | (b_i & c);
  assign borrow = (~a_i & b_i) | (~a_i & c) | (b_i & c);

  always_comb begin
    st_o.sum_p = {1'b0, a_i} + {1'b0, b_i} + {1'b0, c};
    st_o.inv   = (fn_i == FN_AND) || (fn_i == FN_NOR) || (fn_i == FN_XNOR);
    st_o.cout  = 1'b0;
    unique case (fn_i)
      FN_AND, FN_NAND: st_o.sum_n = 2'd2;
      FN_OR,  FN_NOR:  st_o.sum_n = 2'd0;
      default:         st_o.sum_n = {maj, 1'b0};  // parity via sum minus twice majority
    endcase
    if (fn_i == FN_ADD) st_o.cout = maj;
    if (fn_i == FN_SUB) st_o.cout = borrow;
  end
endmodule

// File: rtl/alu_seq_cmp.sv
module alu_seq_cmp
  import alu_seq_pkg::*;
(
  input  slice_st_t st_i,
  output logic      bit_o
);
  // equal sums resolve to 0 before inversion
  assign bit_o = (st_i.sum_p != st_i.sum_n) ^ st_i.inv;
endmodule

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STEP_W = 5,
  parameter int unsigned HALF_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              eval_en_o,
  output logic              xfer_en_o,
  output logic              out_en_o,
  output logic [HALF_W-1:0] half_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(2 * WIDTH);

  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        step_q <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (step_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign half_o    = step_q[STEP_W-1:1];
  assign eval_en_o = busy_o && !step_q[0] && (step_q != LAST);
  assign xfer_en_o = busy_o && step_q[0];
  assign out_en_o  = busy_o && !step_q[0] && (step_q != '0);

  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> step_q <= LAST);  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && ($past(step_q) == LAST));  // R5
endmodule

// File: rtl/alu_seq_top.sv
module alu_seq_top
  import alu_seq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [2:0]       func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             done_o
);
  localparam int unsigned STEP_W = $clog2(2 * WIDTH + 2);
  localparam int unsigned HALF_W = STEP_W - 1;

  logic              busy, eval_en, xfer_en, out_en, start_acc;
  logic [HALF_W-1:0] half;
  logic [WIDTH-1:0]  a_q, b_q, eval_sel, out_sel;
  alu_fn_e           fn_q;
  slice_st_t         eval_st, l_st, t_st;
  logic              a_bit, b_bit, cin, out_bit;

  alu_seq_ctrl #(.WIDTH(WIDTH), .STEP_W(STEP_W), .HALF_W(HALF_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_o    (busy),
    .done_o    (done_o),
    .eval_en_o (eval_en),
    .xfer_en_o (xfer_en),
    .out_en_o  (out_en),
    .half_o    (half)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign eval_sel[i] = eval_en && (half == HALF_W'(i));
    assign out_sel[i]  = out_en && (half == HALF_W'(i + 1));
  end

  assign start_acc = start_i && !busy;
  assign a_bit     = |(a_q & eval_sel);
  assign b_bit     = |(b_q & eval_sel);
  assign cin       = eval_sel[0] ? 1'b0 : t_st.cout;

  alu_seq_slice u_slice (
    .a_i   (a_bit),
    .b_i   (b_bit),
    .cin_i (cin),
    .fn_i  (fn_q),
    .st_o  (eval_st)
  );

  alu_seq_cmp u_cmp (
    .st_i  (t_st),
    .bit_o (out_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      fn_q     <= FN_AND;
      l_st     <= '0;
      t_st     <= '0;
      result_o <= '0;
      carry_o  <= 1'b0;
    end else if (start_acc) begin
      a_q      <= op_a_i;
      b_q      <= op_b_i;
      fn_q     <= alu_fn_e'(func_i);
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      if (eval_en) l_st <= eval_st;
      if (xfer_en) t_st <= l_st;
      if (out_en) begin
        result_o <= result_o | (out_sel & {WIDTH{out_bit}});
        if (out_sel[WIDTH-1]) carry_o <= t_st.cout;
      end
    end
  end

  AST_OPND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q) && $stable(fn_q)));  // R6
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (fn_q != FN_ADD) && (fn_q != FN_SUB)) |-> !carry_o);  // R4
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!busy && !start_i) |-> ($stable(result_o) && $stable(carry_o)));  // R5
  AST_ONE_BIT_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_sel) && $onehot0(eval_sel));  // R7
endmodule

// File: tb/alu_seq_top_tb.sv
module alu_seq_top_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W   = 8;
  localparam int unsigned LAT = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0]   func = '0;
  logic [W-1:0] result;
  logic         carry, done;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int n_done   = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    int           t0;
    string        req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alu_seq_top #(.WIDTH(W)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .func_i   (func),
    .result_o (result),
    .carry_o  (carry),
    .done_o   (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  function automatic void model(input logic [W-1:0] a, b, input logic [2:0] f,
                                output logic [W-1:0] r, output logic c, output string req);
    logic [W:0] s;
    c = 1'b0;
    req = "R1";
    case (f)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: r = ~(a & b);
      3'd3: r = ~(a | b);
      3'd4: r = a ^ b;
      3'd5: r = ~(a ^ b);
      3'd6: begin s = {1'b0, a} + {1'b0, b}; r = s[W-1:0]; c = s[W]; req = "R2"; end
      default: begin r = a - b; c = (a < b); req = "R3"; end
    endcase
  endfunction

  // monitor: pops expected items on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R6", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, e.req, "result", result, e.res);
        check(carry == e.cy, (e.req == "R1") ? "R4" : e.req, "carry", carry, e.cy);
        check(cyc - e.t0 == LAT, "R5", "latency", cyc - e.t0, LAT);
      end
    end
  end

  // driver: one operation; optional per-cycle schedule check; optional mid-run start
  task automatic run_op(input logic [W-1:0] a, b, input logic [2:0] f,
                        input bit sched, input bit intrude);
    exp_t e;
    int   k;
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    func  = f;
    start = 1'b1;
    model(a, b, f, e.res, e.cy, e.req);
    @(negedge clk);
    start = 1'b0;
    e.t0 = cyc;
    sb.push_back(e);
    k = 0;
    while (!done) begin
      if (sched) begin
        int nb;
        logic [W-1:0] msk;
        nb  = (k < 3) ? 0 : (((k - 1) / 2 > int'(W)) ? int'(W) : (k - 1) / 2);
        msk = (nb >= int'(W)) ? '1 : W'((1 << nb) - 1);
        check(result == (e.res & msk), "R7", "partial result", result, e.res & msk);
      end
      if (intrude && k == 5) begin
        op_a  = ~a;
        op_b  = a;
        func  = f ^ 3'd3;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
      if (k > LAT + 4) break;
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    check(result == '0, "R8", "reset result", result, 0);
    check(carry == 1'b0, "R8", "reset carry", carry, 0);
    check(done == 1'b0, "R8", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 each logic code
    for (int f = 0; f < 6; f++) run_op(8'hC5, 8'h6A, 3'(f), 1'b0, 1'b0);
    // R2 carry extremes
    run_op(8'hFF, 8'h01, 3'd6, 1'b0, 1'b0);
    run_op(8'h80, 8'h80, 3'd6, 1'b0, 1'b0);
    run_op(8'h00, 8'h00, 3'd6, 1'b0, 1'b0);
    // R3 borrow extremes
    run_op(8'h00, 8'h01, 3'd7, 1'b0, 1'b0);
    run_op(8'h5A, 8'h5A, 3'd7, 1'b0, 1'b0);
    run_op(8'hFF, 8'h00, 3'd7, 1'b0, 1'b0);
    run_op(8'h01, 8'hFF, 3'd7, 1'b0, 1'b0);
    // R7 schedule with all ones
    run_op(8'hFF, 8'hFF, 3'd0, 1'b1, 1'b0);
    // R6 mid-run start ignored
    run_op(8'h3C, 8'h0F, 3'd6, 1'b0, 1'b1);
    run_op(8'h12, 8'h34, 3'd7, 1'b0, 1'b1);
    d0 = n_done;
    repeat (LAT + 4) @(negedge clk);
    check(n_done == d0, "R6", "no extra done", n_done - d0, 0);
    check(result == 8'hDE, "R5", "result held after done", result, 8'hDE);
    check(carry == 1'b1, "R5", "borrow held after done", carry, 1);
    // random operands and codes
    for (int i = 0; i < 60; i++)
      run_op(W'($urandom), W'($urandom), 3'($urandom), 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R5", "outstanding items", sb.size(), 0);
    summary();
    $finish;
  end
endmodule